// File: doc/BRIEF.md
# AC-link Serial Output Framer

This block drives the outgoing half of an AC'97-style audio link. It runs on the bit clock supplied by the codec. Each frame it raises a frame sync, sends a 16-bit tag slot, then sends twelve 20-bit data slots, most significant bit first. Sync and data change on rising edges of the bit clock so that the codec can sample them on the following falling edge. One frame is 256 bit clocks long.

A producer supplies one frame's worth of payload through a ready/valid handshake. The payload is twelve 16-bit samples plus one valid flag per slot. The framer holds one payload in a staging register while the current frame is being sent. It moves the staged payload into the outgoing frame at the frame boundary. The tag slot is built from the valid flags. Each valid sample is left-aligned in its slot with four zero LSBs. Invalid slots are sent as zeros. Copying a mono sample into both stereo slots is the producer's job.

Top module: `ac_out_framer`

## Requirements
- R1: `sync` is high for exactly 16 consecutive bit clocks at the start of every frame, is low for the other 240, and a frame repeats every 256 bit clocks.
- R2: The first tag bit appears on `sdout` on the rising edge that follows the edge on which `sync` rises, and each later bit of the frame appears on the next rising edge. The last bit of slot 12 therefore shares its edge with the next frame's sync rise.
- R3: Tag bit 15 is sent first and is the OR of all twelve slot valid flags. Tag bit 15-s carries the valid flag of slot s, for s = 1..12. Tag bits 2..0 are zero.
- R4: A valid slot s sends `slot_data[(s-1)*16 +: 16]` MSB first, followed by four zero bits.
- R5: A slot whose valid flag is clear is sent as 20 zero bits, whatever its data input holds.
- R6: `load_ready` is high while the staging register is empty. A payload is taken on a rising edge where `load_valid` and `load_ready` are both high. `load_ready` then stays low until the next frame boundary, which is the edge where `sync` rises.
- R7: At each frame boundary the staged payload becomes the outgoing frame. A payload accepted during frame n goes out in frame n+1. If nothing is staged at a boundary, that frame goes out with no slot valid and all bits zero.
- R8: While `rst_n` is low, `sync` and `sdout` are low and `load_ready` is high. `sync` rises on the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Codec-supplied bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Producer offers a frame payload |
| load_ready | output | 1 | Staging register is empty and can take a payload |
| slot_valid | input | 12 | Per-slot valid flags; bit s-1 belongs to slot s |
| slot_data | input | 192 | Twelve 16-bit samples; slot s in bits (s-1)*16 +: 16 |
| sync | output | 1 | Frame sync to the codec |
| sdout | output | 1 | Serial output data to the codec |

## Verification
The embedded assertions check these properties on every cycle: the 16-clock sync width and the 256-clock period, the zero pad bits, the zero content of slots marked invalid, the frame-valid tag bit, and the rule that the ready flag changes only on an accept or a boundary. Some behaviour can only be shown by the bench's directed frames, which are compared bit for bit against a model built independently of the RTL. These cases are the exact one-clock offset between sync and the first tag bit, the MSB-first ordering of each sample, the placement of each tag flag, and which frame a payload lands in under back-pressure. The bench also shows a last-slot payload whose final bit coincides with the next sync rise.

// File: rtl/ac_out_pkg.sv
package ac_out_pkg;
  localparam int DEF_SLOTS    = 12;
  localparam int DEF_SAMPLE_W = 16;
  localparam int DEF_SLOT_W   = 20;
  localparam int DEF_TAG_W    = 16;

  // True when a frame position lies in the zero padding below a sample.
  function automatic bit in_pad(int pos, int tag_w, int slot_w, int sample_w);
    if (pos < tag_w) return 1'b0;
    return ((pos - tag_w) % slot_w) >= sample_w;
  endfunction

  // Index of the data slot (0-based) covering a frame position.
  function automatic int slot_index(int pos, int tag_w, int slot_w);
    return (pos - tag_w) / slot_w;
  endfunction
endpackage

// File: rtl/ac_frame_counter.sv
module ac_frame_counter #(
  parameter int FRAME_LEN = 256,
  parameter int TAG_W     = 16,
  localparam int POS_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] cnt,
  output logic             boundary,
  output logic             sync_q
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  // cnt is the index of the edge about to happen within the frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
      sync_q <= (int'(cnt) < TAG_W);
    end
  end

  assign boundary = (cnt == '0);

  // checker state: run of sync highs and gap between sync rises
  logic       sync_d;
  logic [4:0] hi_run;
  logic [9:0] gap;
  logic       sync_rise;
  assign sync_rise = sync_q && !sync_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      hi_run <= '0;
      gap    <= '0;
    end else begin
      sync_d <= sync_q;
      hi_run <= sync_q ? ((hi_run == 5'd31) ? hi_run : hi_run + 1'b1) : '0;
      if (sync_rise)          gap <= 10'd1;
      else if (gap != 10'd0 && gap != 10'h3FF) gap <= gap + 1'b1;
    end
  end

  p_sync_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_d && !sync_q) |-> (int'(hi_run) == TAG_W));
  p_sync_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (int'(hi_run) < TAG_W));
  p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && gap != 10'd0) |-> (int'(gap) == FRAME_LEN));
endmodule

// File: rtl/ac_payload_buf.sv
module ac_payload_buf #(
  parameter int SLOTS    = 12,
  parameter int SAMPLE_W = 16,
  localparam int DATA_W  = SLOTS * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [SLOTS-1:0]  in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              boundary,
  output logic [SLOTS-1:0]  act_valid,
  output logic [DATA_W-1:0] act_data
);
  logic              stage_full;
  logic [SLOTS-1:0]  stage_valid;
  logic [DATA_W-1:0] stage_data;
  logic              take;

  assign load_ready = !stage_full;
  assign take       = load_valid && load_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_full  <= 1'b0;
      stage_valid <= '0;
      stage_data  <= '0;
      act_valid   <= '0;
      act_data    <= '0;
    end else begin
      if (boundary) begin
        act_valid <= stage_full ? stage_valid : '0;
        act_data  <= stage_full ? stage_data  : '0;
      end
      if (take) begin
        stage_valid <= in_valid;
        stage_data  <= in_data;
        stage_full  <= 1'b1;
      end else if (boundary) begin
        stage_full  <= 1'b0;
      end
    end
  end

  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_ready) |-> $past(load_valid));
  p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_ready) |-> $past(boundary));
  p_empty_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && load_ready) |=> (act_valid == '0));
endmodule

// File: rtl/ac_bit_serializer.sv
module ac_bit_serializer
  import ac_out_pkg::*;
#(
  parameter int SLOTS     = 12,
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = 16,
  localparam int FRAME_LEN = TAG_W + SLOTS * SLOT_W,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int DATA_W    = SLOTS * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  cnt,
  input  logic [SLOTS-1:0]  act_valid,
  input  logic [DATA_W-1:0] act_data,
  output logic              sd_q
);
  // Bit at a given frame position (0 = first tag bit).
  function automatic logic frame_bit(int pos, logic [SLOTS-1:0] v, logic [DATA_W-1:0] d);
    int s, b;
    if (pos < TAG_W) begin
      if (pos == 0)     return |v;
      if (pos <= SLOTS) return v[pos-1];
      return 1'b0;
    end
    s = slot_index(pos, TAG_W, SLOT_W);
    b = (pos - TAG_W) % SLOT_W;
    if (s >= SLOTS || !v[s] || b >= SAMPLE_W) return 1'b0;
    return d[s*SAMPLE_W + SAMPLE_W - 1 - b];
  endfunction

  // position launched on this edge trails the edge index by one
  int emit_pos;
  assign emit_pos = (cnt == '0) ? FRAME_LEN - 1 : int'(cnt) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= frame_bit(emit_pos, act_valid, act_data);
  end

  logic pad_now, slot_off_now;
  assign pad_now      = in_pad(emit_pos, TAG_W, SLOT_W, SAMPLE_W);
  assign slot_off_now = (emit_pos >= TAG_W) &&
                        !act_valid[slot_index(emit_pos, TAG_W, SLOT_W)];

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pad_now |=> !sd_q);
  p_invalid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_off_now |=> !sd_q);
  p_frame_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_pos == 0) |=> (sd_q == $past(|act_valid)));
endmodule

// File: rtl/ac_out_framer.sv
module ac_out_framer
  import ac_out_pkg::*;
#(
  parameter int SLOTS    = DEF_SLOTS,
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int SLOT_W   = DEF_SLOT_W,
  parameter int TAG_W    = DEF_TAG_W,
  localparam int FRAME_LEN = TAG_W + SLOTS * SLOT_W,
  localparam int POS_W     = $clog2(FRAME_LEN),
  localparam int DATA_W    = SLOTS * SAMPLE_W
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [SLOTS-1:0]  slot_valid,
  input  logic [DATA_W-1:0] slot_data,
  output logic              sync,
  output logic              sdout
);
  logic [POS_W-1:0]  cnt;
  logic              boundary;
  logic [SLOTS-1:0]  act_valid;
  logic [DATA_W-1:0] act_data;

  ac_frame_counter #(.FRAME_LEN(FRAME_LEN), .TAG_W(TAG_W)) u_cnt (
    .clk(bit_clk), .rst_n(rst_n), .cnt(cnt), .boundary(boundary), .sync_q(sync)
  );

  ac_payload_buf #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(bit_clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .in_valid(slot_valid), .in_data(slot_data), .boundary(boundary),
    .act_valid(act_valid), .act_data(act_data)
  );

  ac_bit_serializer #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_ser (
    .clk(bit_clk), .rst_n(rst_n), .cnt(cnt), .act_valid(act_valid),
    .act_data(act_data), .sd_q(sdout)
  );
endmodule

// File: tb/sim_ac_out_framer.sv
module sim_ac_out_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 12;
  localparam int FL = 256;

  logic          bit_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_valid = 1'b0;
  logic [NS-1:0] slot_valid = '0;
  logic [191:0]  slot_data = '0;
  logic          load_ready, sync, sdout;

  int total = 0;
  int bad = 0;

  ac_out_framer u0 (
    .bit_clk(bit_clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .slot_valid(slot_valid), .slot_data(slot_data), .sync(sync), .sdout(sdout)
  );

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected frame, first transmitted bit in bit 255 (R3 R4 R5).
  function automatic logic [255:0] model(input logic [NS-1:0] v, input logic [191:0] d);
    logic [255:0] f;
    logic [15:0]  tag;
    tag = '0;
    tag[15] = |v;
    for (int s = 1; s <= NS; s++) tag[15-s] = v[s-1];
    f = {tag, 240'b0};
    for (int s = 1; s <= NS; s++)
      if (v[s-1]) f[255-16-(s-1)*20 -: 20] = {d[(s-1)*16 +: 16], 4'b0000};
    return f;
  endfunction

  task automatic send(input logic [NS-1:0] v, input logic [191:0] d);
    @(negedge bit_clk);
    while (!load_ready) @(negedge bit_clk);
    slot_valid = v; slot_data = d; load_valid = 1'b1;
    @(negedge bit_clk);
    load_valid = 1'b0; slot_data = '0; slot_valid = '0;
  endtask

  // Capture one frame; if start_now, the current negedge is already the sync-rise sample.
  task automatic capture(input bit start_now, output logic [255:0] bits, output logic [255:0] syn);
    logic prev;
    if (!start_now) begin
      prev = sync;
      forever begin
        @(negedge bit_clk);
        if (sync && !prev) break;
        prev = sync;
      end
    end
    for (int i = 0; i < FL; i++) begin
      @(negedge bit_clk);
      bits[255-i] = sdout;
      syn[255-i]  = sync;
    end
  endtask

  task automatic check_frame(input string name, input logic [255:0] bits, input logic [255:0] syn,
                             input logic [NS-1:0] v, input logic [191:0] d);
    // samples after the rise: 15 more highs, 240 lows, next rise on the 256th (R1)
    logic [255:0] exp_syn;
    exp_syn = {15'h7FFF, 240'b0, 1'b1};
    check(syn == exp_syn, "R1", {name, " sync shape"}, syn, exp_syn);
    // alignment one edge after sync and bit order (R2 R3 R4 R5)
    check(bits == model(v, d), "R2", {name, " stream"}, bits, model(v, d));
  endtask

  function automatic logic [191:0] pattern(input logic [15:0] seed);
    logic [191:0] d;
    for (int s = 0; s < NS; s++) d[s*16 +: 16] = seed ^ (16'h1357 * 16'(s + 1));
    return d;
  endfunction

  task automatic t_reset;
    #(CLK_PERIOD*3);
    @(negedge bit_clk);
    check(sync == 1'b0 && sdout == 1'b0, "R8", "outputs low in reset", {254'b0, sync, sdout}, '0);
    check(load_ready == 1'b1, "R8", "ready in reset", {255'b0, load_ready}, 256'd1);
    rst_n = 1'b1;
    @(negedge bit_clk);
    check(sync == 1'b1, "R8", "sync on first edge", {255'b0, sync}, 256'd1);
  endtask

  task automatic t_empty;
    logic [255:0] b, y;
    capture(1'b0, b, y);
    check_frame("empty R7", b, y, '0, '0);
  endtask

  task automatic t_full;
    logic [255:0] b, y;
    logic [191:0] d;
    d = pattern(16'hA5C3);
    send('1, d);
    capture(1'b0, b, y);
    check_frame("all-valid R3 R4", b, y, '1, d);
  endtask

  task automatic t_sparse;
    logic [255:0] b, y;
    logic [191:0] d;
    logic [NS-1:0] v;
    d = pattern(16'hFFFF);
    v = 12'b1010_0110_0001;
    send(v, d);
    capture(1'b0, b, y);
    check_frame("sparse R5", b, y, v, d);
  endtask

  task automatic t_backpressure;
    logic [255:0] b1, y1, b2, y2, b3, y3;
    logic [191:0] da, db;
    da = pattern(16'h8001);
    db = pattern(16'h7E42);
    send(12'h800, da);
    check(load_ready == 1'b0, "R6", "ready low after accept", {255'b0, load_ready}, '0);
    fork
      capture(1'b0, b1, y1);
      send(12'h001, db);
    join
    check_frame("first of pair R6 R7", b1, y1, 12'h800, da);
    capture(1'b1, b2, y2);
    check_frame("second of pair R6 R7", b2, y2, 12'h001, db);
    capture(1'b1, b3, y3);
    check_frame("idle after pair R7", b3, y3, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_empty();
    t_full();
    t_sparse();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule